// File: doc/BRIEF.md
# Pin Control Register Bank with Set/Clear Aliases

This block holds the per-pin control state for a group of general-purpose pins on a plain 32-bit register bus. It keeps three stateful registers: output level, output enable and interrupt status. The default build has 35 pins. The lower 32 pins fill one bus word. The remaining pins occupy the low bits of a second word, whose upper bits are reserved. A fourth, read-only group returns the pad levels after a two-flop synchronizer.

Each stateful register can be reached at three addresses:

- A direct address, which loads the whole word.
- A set alias, where every 1 written forces the matching bit high.
- A clear alias, where every 1 written forces the matching bit low.

The aliases let firmware change single pins without a read-modify-write. Hardware event pulses can also raise interrupt-status bits. Pad drivers, the bus fabric and interrupt routing live outside the block.

Top module: `gpio_bank_regs`

## Requirements
- R1: After a synchronous reset, every output, enable and status bit is 0, and the read data port is 0.
- R2: The word address `bus_addr[4:0]` is split into three fields. Bits [4:3] select the group: 0 is output level, 1 is output enable, 2 is interrupt status and 3 is pad input. Bit 2 selects the word: 0 holds pins 0–31 and 1 holds pins 32–34 in bits [2:0]. Bits [1:0] select the form: 0 is direct, 1 is set alias, 2 is clear alias and 3 is unused. A write to the direct form loads the word, and a read of the direct form returns it.
- R3: In a write to a set alias, each 1 bit forces the matching register bit to 1, and each 0 bit leaves it unchanged.
- R4: In a write to a clear alias, each 1 bit forces the matching register bit to 0, and each 0 bit leaves it unchanged.
- R5: In the upper word of any group, bits [31:3] always read 0, and writes to them in any form are ignored.
- R6: A read of a set alias, a clear alias or the unused form 3 returns 0.
- R7: A read of the pad input group at form 0 returns the pad levels after a two-flop synchronizer. A pad change is therefore invisible to read strobes in the first two cycles after the change and visible from the third.
- R8: A pulse on `hw_evt[n]` sets interrupt-status bit n at the next clock edge. If a software write in the same cycle would clear that bit, the hardware set wins.
- R9: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. Writes to the pad input group are ignored.
- R10: `pin_out`, `pin_oe` and `irq_status` show the register state. A write changes them at the first clock edge after the write strobe. Without a write they do not change, except that `irq_status` also changes on hardware events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address (group, word, form) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 35 | Asynchronous pad levels |
| hw_evt | input | 35 | Hardware interrupt-status set pulses |
| pin_out | output | 35 | Output level per pin |
| pin_oe | output | 35 | Output enable per pin |
| irq_status | output | 35 | Interrupt status per pin |

## Verification
The assertions check the following on every cycle:

- A set-alias write leaves all written ones high.
- A clear-alias write leaves all written ones low.
- A hardware event is always visible at the next edge, whatever the bus does.
- Alias and reserved read data are zero.
- The output level does not move without a write.

Only the directed scenarios can show the rest:

- Exact direct-write values and the full address map.
- The two-cycle input latency.
- That zero bits in an alias write leave the other pins untouched.
- That writes to the pad group are ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 5;
  localparam int NSTATE = 3;

  typedef enum logic [1:0] {
    GRP_OUT = 2'd0,
    GRP_OE  = 2'd1,
    GRP_STS = 2'd2,
    GRP_PAD = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    FORM_DIR  = 2'd0,
    FORM_SET  = 2'd1,
    FORM_CLR  = 2'd2,
    FORM_NONE = 2'd3
  } form_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_bank_pkg::*;
(
  input  logic                         wr,
  input  logic [REG_AW-1:0]            addr,
  output logic [NSTATE-1:0][1:0]       we_dir,
  output logic [NSTATE-1:0][1:0]       we_set,
  output logic [NSTATE-1:0][1:0]       we_clr
);
  logic [1:0] grp;
  logic       word;
  logic [1:0] form;

  assign grp  = addr[4:3];
  assign word = addr[2];
  assign form = addr[1:0];

  always_comb begin
    we_dir = '0;
    we_set = '0;
    we_clr = '0;
    for (int g = 0; g < NSTATE; g++) begin
      if (wr && grp == 2'(g)) begin
        we_dir[g][word] = (form == FORM_DIR);
        we_set[g][word] = (form == FORM_SET);
        we_clr[g][word] = (form == FORM_CLR);
      end
    end
  end
endmodule

// File: rtl/gpio_wreg.sv
module gpio_wreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_dir,
  input  logic             we_set,
  input  logic             we_clr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = q;
    if (we_dir)      nxt = wdata;
    else if (we_set) nxt = q | wdata;
    else if (we_clr) nxt = q & ~wdata;
    nxt = nxt | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 35,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] hw_evt,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] irq_status
);
  localparam int HI_W  = NUM_PINS - DATA_W;
  localparam int PAD_W = 2 * DATA_W - NUM_PINS;

  logic [NSTATE-1:0][1:0]          we_dir, we_set, we_clr;
  logic [NSTATE-1:0][NUM_PINS-1:0] grp_q;
  logic [NSTATE-1:0][NUM_PINS-1:0] hw_vec;
  logic [NUM_PINS-1:0]             pad_sync;
  logic [NUM_PINS-1:0]             rd_src;
  logic [DATA_W-1:0]               rd_next;

  assign hw_vec = {hw_evt, {NUM_PINS{1'b0}}, {NUM_PINS{1'b0}}};

  gpio_decode u_dec (
    .wr     (bus_wr),
    .addr   (bus_addr),
    .we_dir (we_dir),
    .we_set (we_set),
    .we_clr (we_clr)
  );

  for (genvar g = 0; g < NSTATE; g++) begin : g_grp
    gpio_wreg #(.WIDTH(DATA_W)) u_lo (
      .clk    (clk),
      .rst    (rst),
      .we_dir (we_dir[g][0]),
      .we_set (we_set[g][0]),
      .we_clr (we_clr[g][0]),
      .wdata  (bus_wdata),
      .hw_set (hw_vec[g][DATA_W-1:0]),
      .q      (grp_q[g][DATA_W-1:0])
    );
    gpio_wreg #(.WIDTH(HI_W)) u_hi (
      .clk    (clk),
      .rst    (rst),
      .we_dir (we_dir[g][1]),
      .we_set (we_set[g][1]),
      .we_clr (we_clr[g][1]),
      .wdata  (bus_wdata[HI_W-1:0]),
      .hw_set (hw_vec[g][NUM_PINS-1:DATA_W]),
      .q      (grp_q[g][NUM_PINS-1:DATA_W])
    );
  end

  gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  always_comb begin
    case (bus_addr[4:3])
      GRP_OUT: rd_src = grp_q[0];
      GRP_OE:  rd_src = grp_q[1];
      GRP_STS: rd_src = grp_q[2];
      default: rd_src = pad_sync;
    endcase
    rd_next = '0;
    if (bus_addr[1:0] == FORM_DIR) begin
      if (bus_addr[2]) rd_next = {{PAD_W{1'b0}}, rd_src[NUM_PINS-1:DATA_W]};
      else             rd_next = rd_src[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign pin_out    = grp_q[0];
  assign pin_oe     = grp_q[1];
  assign irq_status = grp_q[2];
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 35,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [REG_AW-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] hw_evt,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] irq_status
);
  localparam logic [REG_AW-1:0] A_OUT0_SET = {GRP_OUT, 1'b0, FORM_SET};
  localparam logic [REG_AW-1:0] A_OUT0_CLR = {GRP_OUT, 1'b0, FORM_CLR};

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_OUT0_SET) |=>
      ((pin_out[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));  // R3

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_OUT0_CLR) |=>
      ((pin_out[DATA_W-1:0] & $past(bus_wdata)) == '0));  // R4

  AST_HW_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|hw_evt) |=> ((irq_status & $past(hw_evt)) == $past(hw_evt)));  // R8

  AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[2]) |=> (bus_rdata[DATA_W-1:NUM_PINS-DATA_W] == '0));  // R5

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[1:0] != FORM_DIR) |=> (bus_rdata == '0));  // R6

  AST_OUT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(pin_out));  // R10
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .hw_evt     (hw_evt),
  .pin_out    (pin_out),
  .irq_status (irq_status)
);

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [34:0] pad_in, hw_evt, pin_out, pin_oe, irq_status;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_bank_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .hw_evt(hw_evt),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_status(irq_status)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    chk(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 pin_out", {29'd0, pin_out}, 64'd0);
    chk("R1 pin_oe", {29'd0, pin_oe}, 64'd0);
    chk("R1 irq_status", {29'd0, irq_status}, 64'd0);
    chk("R1 rdata", {32'd0, bus_rdata}, 64'd0);
    rd_chk("R1 sts1 read", 5'h14, 32'h0);
  endtask

  task automatic t_direct_set_clr();
    wr(5'h00, 32'hA5A5_0F0F);
    chk("R10 pin_out after direct", {29'd0, pin_out}, {29'd0, 35'h0_A5A5_0F0F});
    rd_chk("R2 out0 direct read", 5'h00, 32'hA5A5_0F0F);
    wr(5'h01, 32'h0000_F000);
    rd_chk("R3 out0 after set alias", 5'h00, 32'hA5A5_FF0F);
    wr(5'h02, 32'hA500_0000);
    rd_chk("R4 out0 after clear alias", 5'h00, 32'h00A5_FF0F);
    wr(5'h09, 32'h8000_0001);
    wr(5'h0A, 32'h0000_0001);
    chk("R3 R4 pin_oe set then clear", {29'd0, pin_oe}, {29'd0, 35'h0_8000_0000});
    rd_chk("R2 oe0 read", 5'h08, 32'h8000_0000);
  endtask

  task automatic t_high_word();
    wr(5'h04, 32'hFFFF_FFFD);
    rd_chk("R5 out1 reserved bits", 5'h04, 32'h0000_0005);
    chk("R5 pin_out upper", {61'd0, pin_out[34:32]}, 64'd5);
    wr(5'h0D, 32'hFFFF_FFF8);
    rd_chk("R5 oe1 reserved set ignored", 5'h0C, 32'h0);
    wr(5'h0D, 32'h0000_0002);
    wr(5'h0E, 32'hFFFF_FFF0);
    rd_chk("R5 oe1 reserved clear ignored", 5'h0C, 32'h0000_0002);
  endtask

  task automatic t_alias_reads();
    rd_chk("R6 set alias read", 5'h01, 32'h0);
    rd_chk("R6 clear alias read", 5'h02, 32'h0);
    rd_chk("R6 unused form read", 5'h03, 32'h0);
    rd_chk("R6 pad set form read", 5'h19, 32'h0);
  endtask

  task automatic t_pad_sync();
    pad_in = 35'h5_1234_5678;
    rd_chk("R7 pad not yet visible c1", 5'h18, 32'h0);
    rd_chk("R7 pad not yet visible c2", 5'h18, 32'h0);
    rd_chk("R7 pad visible c3", 5'h18, 32'h1234_5678);
    rd_chk("R7 pad upper word", 5'h1C, 32'h0000_0005);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h19, 32'hFFFF_FFFF);
    rd_chk("R9 pad write ignored", 5'h18, 32'h1234_5678);
  endtask

  task automatic t_hw_event();
    hw_evt = 35'd0; hw_evt[7] = 1'b1;
    @(posedge clk); @(negedge clk);
    hw_evt = '0;
    chk("R8 hw event sets bit", {63'd0, irq_status[7]}, 64'd1);
    wr(5'h15, 32'h0000_0002);
    hw_evt = 35'd0; hw_evt[33] = 1'b1;
    bus_wr = 1'b1; bus_addr = 5'h16; bus_wdata = 32'h0000_0002;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; hw_evt = '0;
    chk("R8 hw set beats clear", {63'd0, irq_status[33]}, 64'd1);
    wr(5'h16, 32'h0000_0002);
    chk("R4 status clear alone", {63'd0, irq_status[33]}, 64'd0);
    rd_chk("R2 status0 read", 5'h10, 32'h0000_0080);
  endtask

  task automatic t_read_hold();
    rd_chk("R9 read latency", 5'h00, 32'h00A5_FF0F);
    @(posedge clk); @(negedge clk);
    chk("R9 rdata holds", {32'd0, bus_rdata}, {32'd0, 32'h00A5_FF0F});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; hw_evt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct_set_clr();
    t_high_word();
    t_alias_reads();
    t_pad_sync();
    t_hw_event();
    t_read_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule